// File: doc/BRIEF.md
# Two-Slot Cell Transmit Buffer

This block sits on the transmit side of one output data port of a cell switch. A controller in the system-clock domain writes a whole fixed-length cell into the buffer one byte at a time. The buffer has two cell slots, so one cell can be written while the other goes out on the port. The port side runs on its own clock. It reads the oldest complete cell, splits each byte into narrow transfers and raises a start-of-cell strobe with the first transfer of every cell.

The output cell length is set in the system-clock domain by a 3-bit code, and this setting has no link to the length used on the receive side. The code is captured when the first byte of a cell is written, and the cell keeps that length until its last transfer. Two status flags in the system domain tell the controller when it can write the next cell: one says the next slot to be written is free, and the other says both slots are empty. Slot handoff crosses between the clocks through toggle flags passed through synchronizer chains.

Both sides use valid/ready. On the load side, `ld_ready` is low during reset and high from then on. Every byte offered with `ld_valid` is taken, and a cell aimed at an occupied slot is thrown away rather than stalled. On the port side, a transfer happens on a port clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the presented transfer is held unchanged.

Top module: `cell_tx_buffer`

## Requirements
- R1: During reset `ld_ready` is 0. After reset `ld_ready`=1, `tx_empty`=1, `slot_free`=1, `ld_err`=0, `out_valid`=0, `out_soc`=0 and `out_data`=0.
- R2: `len_sel` codes 0,1,2,3,4 give cells of 52,53,54,55,56 bytes, and codes 5 to 7 give 56 bytes. The code is sampled with the first byte of a cell and applies to that whole cell, including its transmission.
- R3: Each byte goes out as 8/PORT_W transfers, most significant bits first. Bytes are sent in the order they were loaded. A cell of L bytes takes exactly L*8/PORT_W transfers.
- R4: `out_soc` is high on exactly one accepted transfer per cell: the first one.
- R5: When no complete cell is held, `out_valid`, `out_soc` and `out_data` are all 0.
- R6: While `out_valid`=1 and `out_ready`=0, on the next port clock `out_valid` stays 1, and `out_data` and `out_soc` keep their values.
- R7: Two cells can be held without any transmission, and they leave in load order. `slot_free` is 1 when the next slot to be written is empty. `tx_empty` is 1 when both slots are empty, and it returns to 1 a few system cycles after the last transfer.
- R8: A cell whose first byte arrives while the target slot is occupied is discarded in full. `ld_err` pulses high for one system cycle, the cycle after that first byte is taken. The held cells are not changed, and the discarded cell is never sent.
- R9: A cell can be loaded into the free slot while the other slot is transmitting. It then follows with no loss or corruption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Controller-side clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset, system domain |
| len_sel | input | 3 | Output cell length code |
| ld_valid | input | 1 | Load byte valid |
| ld_ready | output | 1 | Load side accepts bytes |
| ld_data | input | 8 | Load byte |
| ld_err | output | 1 | One-cycle pulse: cell rejected because its slot is occupied |
| tx_empty | output | 1 | Both slots empty |
| slot_free | output | 1 | Next slot to be loaded is empty |
| port_clk | input | 1 | Port data clock |
| port_rst_n | input | 1 | Asynchronous active-low reset, port domain |
| out_valid | output | 1 | Transfer valid |
| out_ready | input | 1 | Port accepts transfer |
| out_data | output | PORT_W | Transfer data |
| out_soc | output | 1 | Start-of-cell strobe on first transfer |

## Verification
Cells are sent with an always-ready port and with a port that stalls every third clock. The first case checks the plain nibble order, and the second shows that held transfers and the start-of-cell strobe survive back-pressure. Cells of every length are used, including an out-of-range code and a length change between two cells in flight. A wrong length shows up as a wrong transfer count. The slots are filled with the port stalled and a third cell is then offered, which separates a correct rejection from an overwrite of the held cells. Loading during transmission checks that a slot handoff across the clocks neither loses a cell nor sends it twice.

// File: rtl/cell_tx_pkg.sv
package cell_tx_pkg;
  localparam int CELL_MIN  = 52;
  localparam int CELL_MAX  = 56;
  localparam int LEN_W     = $clog2(CELL_MAX + 1);
  localparam int NSLOT     = 2;

  typedef logic [7:0]       byte_t;
  typedef logic [LEN_W-1:0] len_t;

  // 0..4 -> 52..56 bytes, 5..7 -> 56 bytes
  function automatic len_t len_decode(input logic [2:0] sel);
    if (sel > 3'd4) return len_t'(CELL_MAX);
    return len_t'(CELL_MIN) + len_t'(sel);
  endfunction
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= {st[STAGES-2:0], d};
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cell_slot_mem.sv
module cell_slot_mem
  import cell_tx_pkg::*;
#(
  parameter int DEPTH = CELL_MAX,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic          wslot,
  input  logic [AW-1:0] waddr,
  input  byte_t         wdata,
  input  logic          rslot,
  input  logic [AW-1:0] raddr,
  output byte_t         rdata
);
  byte_t mem [NSLOT][DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[wslot][waddr] <= wdata;
  end

  assign rdata = mem[rslot][raddr];
endmodule

// File: rtl/cell_wr_ctrl.sv
module cell_wr_ctrl
  import cell_tx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            len_sel,
  input  logic                  ld_valid,
  output logic                  ld_ready,
  input  byte_t                 ld_data,
  output logic                  ld_err,
  input  logic [NSLOT-1:0]      rd_tog_s,
  output logic [NSLOT-1:0]      wr_tog,
  output logic [NSLOT-1:0][LEN_W-1:0] slot_len,
  output logic                  mem_we,
  output logic                  mem_slot,
  output logic [LEN_W-1:0]      mem_addr,
  output byte_t                 mem_wdata,
  output logic                  tx_empty,
  output logic                  slot_free
);
  logic [NSLOT-1:0] full;
  logic             wr_sel;
  len_t             wcnt;
  len_t             cur_len;
  logic             discard;
  logic             fire, first, reject, last;
  len_t             len_now;

  assign full     = wr_tog ^ rd_tog_s;
  assign fire     = ld_valid & ld_ready;
  assign first    = (wcnt == '0);
  assign len_now  = first ? len_decode(len_sel) : cur_len;
  assign reject   = first ? full[wr_sel] : discard;
  assign last     = (wcnt == len_now - len_t'(1));

  assign mem_we    = fire & ~reject;
  assign mem_slot  = wr_sel;
  assign mem_addr  = wcnt;
  assign mem_wdata = ld_data;
  assign tx_empty  = ~|full;
  assign slot_free = ~full[wr_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_ready <= 1'b0;
      ld_err   <= 1'b0;
      wr_sel   <= 1'b0;
      wcnt     <= '0;
      cur_len  <= len_t'(CELL_MAX);
      discard  <= 1'b0;
      wr_tog   <= '0;
      slot_len <= '{default: len_t'(CELL_MAX)};
    end else begin
      ld_ready <= 1'b1;
      ld_err   <= fire & first & full[wr_sel];
      if (fire) begin
        if (first) begin
          cur_len <= len_now;
          discard <= full[wr_sel];
          if (!full[wr_sel]) slot_len[wr_sel] <= len_now;
        end
        if (last) begin
          wcnt <= '0;
          if (!reject) begin
            wr_tog[wr_sel] <= ~wr_tog[wr_sel];
            wr_sel         <= ~wr_sel;
          end
        end else begin
          wcnt <= wcnt + len_t'(1);
        end
      end
    end
  end

  // R8
  no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !full[mem_slot]);

  // R8
  reject_keeps_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last && reject) |=> (wr_tog == $past(wr_tog)));

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_err |=> !ld_err);

  // R2
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (len_now >= len_t'(CELL_MIN) && len_now <= len_t'(CELL_MAX)));
endmodule

// File: rtl/cell_rd_ser.sv
module cell_rd_ser
  import cell_tx_pkg::*;
#(
  parameter int PORT_W = 4,
  localparam int SUBS  = 8 / PORT_W,
  localparam int SUB_W = (SUBS > 1) ? $clog2(SUBS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSLOT-1:0]            wr_tog_s,
  input  logic [NSLOT-1:0][LEN_W-1:0] slot_len,
  output logic [NSLOT-1:0]            rd_tog,
  output logic                        rd_slot,
  output logic [LEN_W-1:0]            rd_addr,
  input  byte_t                       rd_byte,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [PORT_W-1:0]           out_data,
  output logic                        out_soc
);
  logic             rd_sel;
  len_t             bidx;
  logic [SUB_W-1:0] sub;
  logic             have, fire, last_sub, last_byte;
  len_t             rd_len;
  logic [2:0]       shamt;

  assign have      = wr_tog_s[rd_sel] ^ rd_tog[rd_sel];
  assign rd_len    = slot_len[rd_sel];
  assign fire      = have & out_ready;
  assign last_sub  = (int'(sub) == SUBS - 1);
  assign last_byte = (bidx == rd_len - len_t'(1));
  assign shamt     = 3'((SUBS - 1 - int'(sub)) * PORT_W);

  assign rd_slot   = rd_sel;
  assign rd_addr   = bidx;
  assign out_valid = have;
  assign out_data  = have ? PORT_W'(rd_byte >> shamt) : '0;
  assign out_soc   = have & (bidx == '0) & (sub == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sel <= 1'b0;
      bidx   <= '0;
      sub    <= '0;
      rd_tog <= '0;
    end else if (fire) begin
      if (last_sub) begin
        sub <= '0;
        if (last_byte) begin
          bidx           <= '0;
          rd_tog[rd_sel] <= ~rd_tog[rd_sel];
          rd_sel         <= ~rd_sel;
        end else begin
          bidx <= bidx + len_t'(1);
        end
      end else begin
        sub <= sub + SUB_W'(1);
      end
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_soc)));

  // R4
  soc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_soc && out_ready) |=> !out_soc);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_soc && out_data == '0));

  // R3
  index_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    have |-> (bidx < rd_len));
endmodule

// File: rtl/cell_tx_buffer.sv
module cell_tx_buffer
  import cell_tx_pkg::*;
#(
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic [2:0]        len_sel,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [7:0]        ld_data,
  output logic              ld_err,
  output logic              tx_empty,
  output logic              slot_free,
  input  logic              port_clk,
  input  logic              port_rst_n,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PORT_W-1:0] out_data,
  output logic              out_soc
);
  logic [NSLOT-1:0]            wr_tog, wr_tog_s, rd_tog, rd_tog_s;
  logic [NSLOT-1:0][LEN_W-1:0] slot_len;
  logic                        mem_we, mem_slot, rd_slot;
  logic [LEN_W-1:0]            mem_addr, rd_addr;
  byte_t                       mem_wdata, rd_byte;

  for (genvar s = 0; s < NSLOT; s++) begin : g_sync
    bit_sync #(.STAGES(SYNC_STAGES)) u_w2p (
      .clk(port_clk), .rst_n(port_rst_n), .d(wr_tog[s]), .q(wr_tog_s[s]));
    bit_sync #(.STAGES(SYNC_STAGES)) u_p2w (
      .clk(sys_clk), .rst_n(sys_rst_n), .d(rd_tog[s]), .q(rd_tog_s[s]));
  end

  cell_wr_ctrl u_wr (
    .clk(sys_clk), .rst_n(sys_rst_n), .len_sel(len_sel),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data), .ld_err(ld_err),
    .rd_tog_s(rd_tog_s), .wr_tog(wr_tog), .slot_len(slot_len),
    .mem_we(mem_we), .mem_slot(mem_slot), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .tx_empty(tx_empty), .slot_free(slot_free));

  cell_slot_mem #(.DEPTH(CELL_MAX)) u_mem (
    .wclk(sys_clk), .we(mem_we), .wslot(mem_slot), .waddr(mem_addr), .wdata(mem_wdata),
    .rslot(rd_slot), .raddr(rd_addr), .rdata(rd_byte));

  cell_rd_ser #(.PORT_W(PORT_W)) u_rd (
    .clk(port_clk), .rst_n(port_rst_n), .wr_tog_s(wr_tog_s), .slot_len(slot_len),
    .rd_tog(rd_tog), .rd_slot(rd_slot), .rd_addr(rd_addr), .rd_byte(rd_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_soc(out_soc));
endmodule

// File: tb/cell_tx_buffer_tb.sv
module cell_tx_buffer_tb;
  localparam int PW   = 4;
  localparam int SUBS = 8 / PW;

  logic sys_clk = 0, port_clk = 0, sys_rst_n = 0, port_rst_n = 0;
  logic [2:0] len_sel = 0;
  logic ld_valid = 0, out_ready = 0;
  logic [7:0] ld_data = 0;
  logic ld_ready, ld_err, tx_empty, slot_free, out_valid, out_soc;
  logic [PW-1:0] out_data;
  int n_tests = 0, n_fail = 0;

  always #4 sys_clk = ~sys_clk;
  always #5.5 port_clk = ~port_clk;

  cell_tx_buffer #(.PORT_W(PW)) u_dut (.*);

  function automatic int len_of(input logic [2:0] sel);
    return (sel > 3'd4) ? 56 : 52 + int'(sel);
  endfunction

  function automatic logic [7:0] pat(input logic [7:0] seed, input int j);
    return seed ^ 8'(j * 37 + 5);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sys_wait(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic load_cell(input logic [2:0] sel, input logic [7:0] seed, input bit exp_err);
    int nb = len_of(sel);
    int errs = 0;
    logic first_err = 0;
    @(negedge sys_clk);
    while (!ld_ready) @(negedge sys_clk);
    len_sel = sel;
    ld_valid = 1;
    for (int j = 0; j < nb; j++) begin
      ld_data = pat(seed, j);
      @(negedge sys_clk);
      if (j == 0) first_err = ld_err;
      errs += int'(ld_err);
    end
    ld_valid = 0;
    repeat (2) begin @(negedge sys_clk); errs += int'(ld_err); end
    check(first_err == exp_err, "R8", "ld_err after first byte", int'(first_err), int'(exp_err));
    check(errs == int'(exp_err), "R8", "ld_err pulse count", errs, int'(exp_err));
  endtask

  task automatic recv_cell(input int nb, input logic [7:0] seed, input bit stall, input string req);
    int units = nb * SUBS;
    int n = 0, socs = 0, misplaced = 0, hold_bad = 0, bad_bytes = 0, guard = 0, cyc = 0;
    logic prev_st = 0, ps = 0, r;
    logic [PW-1:0] pd = '0;
    logic [7:0] got [56];
    for (int k = 0; k < 56; k++) got[k] = '0;
    while (n < units && guard < 20000) begin
      @(negedge port_clk);
      guard++;
      r = stall ? (cyc % 3 != 1) : 1'b1;
      cyc++;
      if (prev_st && (!out_valid || out_data != pd || out_soc != ps)) hold_bad++;
      out_ready = r;
      if (out_valid && r) begin
        if (out_soc) begin socs++; if (n != 0) misplaced++; end
        got[n / SUBS] = (got[n / SUBS] << PW) | 8'(out_data);
        n++;
      end
      prev_st = out_valid && !r;
      pd = out_data; ps = out_soc;
    end
    @(negedge port_clk);
    out_ready = 0;
    for (int j = 0; j < nb; j++) if (got[j] != pat(seed, j)) bad_bytes++;
    check(n == units, "R3", {req, " transfer count"}, n, units);
    check(bad_bytes == 0, "R3", {req, " byte order/content mismatches"}, bad_bytes, 0);
    check(socs == 1 && misplaced == 0, "R4", {req, " start-of-cell strobes"}, socs, 1);
    if (stall) check(hold_bad == 0, "R6", "held transfer changed under stall", hold_bad, 0);
  endtask

  task automatic expect_idle(input string req);
    @(negedge port_clk);
    check(!out_valid && !out_soc && out_data == '0, req, "port idle (valid,soc,data)",
          {out_valid, out_soc, out_data}, 0);
  endtask

  task automatic t_reset;
    check(ld_ready == 0, "R1", "ld_ready in reset", int'(ld_ready), 0);
    sys_rst_n = 1; port_rst_n = 1;
    sys_wait(3);
    check(ld_ready == 1, "R1", "ld_ready after reset", int'(ld_ready), 1);
    check(tx_empty && slot_free && !ld_err, "R1", "status after reset",
          {tx_empty, slot_free, ld_err}, 6);
    expect_idle("R1");
  endtask

  task automatic t_single;
    load_cell(3'd0, 8'h11, 0);
    sys_wait(2);
    check(!tx_empty && slot_free, "R7", "one cell held: tx_empty,slot_free", {tx_empty, slot_free}, 1);
    recv_cell(52, 8'h11, 0, "R2 len 52");
    expect_idle("R5");
    sys_wait(8);
    check(tx_empty == 1, "R7", "tx_empty after drain", int'(tx_empty), 1);
  endtask

  task automatic t_lengths;
    load_cell(3'd2, 8'h5a, 0);
    recv_cell(54, 8'h5a, 0, "R2 len 54");
    load_cell(3'd4, 8'hc3, 0);
    recv_cell(56, 8'hc3, 1, "R2 len 56");
    load_cell(3'd7, 8'h3c, 0);
    recv_cell(56, 8'h3c, 0, "R2 code 7 -> 56");
    load_cell(3'd1, 8'h77, 0);
    recv_cell(53, 8'h77, 0, "R2 len 53");
    expect_idle("R5");
  endtask

  task automatic t_double;
    out_ready = 0;
    load_cell(3'd1, 8'ha0, 0);
    load_cell(3'd3, 8'hb1, 0);
    sys_wait(2);
    check(!slot_free && !tx_empty, "R7", "both full: slot_free,tx_empty", {slot_free, tx_empty}, 0);
    load_cell(3'd0, 8'hee, 1);
    sys_wait(2);
    check(!slot_free, "R8", "slots still full after reject", int'(slot_free), 0);
    recv_cell(53, 8'ha0, 0, "R7 first in order");
    recv_cell(55, 8'hb1, 0, "R8 second intact");
    expect_idle("R8");
    sys_wait(8);
    check(tx_empty == 1, "R7", "tx_empty after two cells", int'(tx_empty), 1);
  endtask

  task automatic t_overlap;
    load_cell(3'd0, 8'h21, 0);
    fork
      recv_cell(52, 8'h21, 0, "R9 A");
      load_cell(3'd4, 8'h42, 0);
    join
    recv_cell(56, 8'h42, 1, "R9 B length kept per cell");
    expect_idle("R9");
    sys_wait(8);
    check(tx_empty == 1, "R9", "tx_empty after overlap", int'(tx_empty), 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge sys_clk);
        t_reset();
        t_single();
        t_lengths();
        t_double();
        t_overlap();
      end
      begin
        repeat (150000) @(posedge sys_clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule